// File: doc/BRIEF.md
# Micro-op Allocation Stage with Load-Balanced Port Binding

This block sits at the end of an out-of-order core's allocate pipeline. Each cycle it looks at a group of micro-op slots. For each one it decides whether the slot can enter the back end. It does this by testing the free-entry counts of the reorder buffer, the load queue, the store queue and the reservation station in a fixed priority. It then raises one insert strobe for each structure the micro-op takes. The structures themselves are outside the block. Here they appear only as free counts coming in and insert strobes going out.

A micro-op that executes is bound to one issue port. The port is taken from the candidate set of its functional-unit class, and the choice uses per-port load counters. The block also computes the micro-op's ready time from the tag-ready times of its parents. NOPs, fences and traps skip execution entirely. They are issued at once, and all of them except the load fence also complete at once. A drain-flush mode can hold allocation off until the reorder buffer has emptied after a recovery.

Top module: `alloc_stage`

## Requirements
- R1: Checks run in a fixed order: ROB, then load queue, then store queue, then reservation station. The first check that fails sets `stallCode`. The codes are 0 none, 1 drain, 2 ROB, 3 load queue, 4 store queue and 5 reservation station.
- R2: A failing slot is not allocated. No later slot is allocated in that cycle either. A slot whose valid bit is low is skipped and does not stop the slots after it.
- R3: Within a cycle, each slot's demand is compared with the free count minus the entries that earlier slots claimed in the same cycle.
- R4: Only a micro-op with `slotFuseBody`=0 needs and takes a ROB entry or a reservation-station entry. A fused body takes neither.
- R5: Kind codes are 0 ALU, 1 load, 2 store-address, 3 store-data, 4 load fence, 5 store fence, 6 NOP and 7 trap. Loads and load fences need a load-queue entry. Store-address micro-ops and store fences need a store-queue entry. A store-data micro-op needs no store-queue check and raises `stqFill`.
- R6: Kinds 4 to 7 skip the reservation-station check and port binding, so `portVld` is 0. They get `issueNow`=1 and `readyTime`=`curTime`. `completeNow` is 1 for all of them except the load fence.
- R7: When the candidate mask in `CLASS_PORTS` for a class has one bit set, every micro-op of that class binds to that port.
- R8: With several candidates, the port with the smallest load counter wins. On a tie the lowest port index wins. The chosen counter is incremented, and a later slot in the same cycle sees the incremented value.
- R9: Load counters stop at 2^LOAD_W-1. `loadClr` zeroes all of them at the next edge, and it takes priority over that cycle's increments.
- R10: An executing micro-op's `readyTime` is the maximum over its sources. A source with `srcLive`=1 contributes its own `srcTime`; a source with `srcLive`=0 contributes `curTime`.
- R11: `drainStart` while `drainMode`=1 sets `drainBusy` at the next edge. `drainStart` while `drainMode`=0 is ignored. While `drainBusy`=1 and `robEmpty`=0, nothing is allocated and the code is 1. When `robEmpty`=1, allocation proceeds in that same cycle and `drainBusy` clears at the next edge.
- R12: After reset, `drainBusy` is 0 and every load counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curTime | input | TIME_W | Current cycle stamp |
| slotValid | input | SLOTS | Slot holds a micro-op |
| slotKind | input | SLOTS x 3 | Micro-op kind code |
| slotFuseBody | input | SLOTS | Micro-op is a fused body, not a head |
| slotClass | input | SLOTS x CLS_W | Functional-unit class |
| srcLive | input | SLOTS x NUM_SRC | Source has an in-flight parent |
| srcTime | input | SLOTS x NUM_SRC x TIME_W | Parent tag-ready time |
| robFree | input | CNT_W | Free ROB entries |
| ldqFree | input | CNT_W | Free load-queue entries |
| stqFree | input | CNT_W | Free store-queue entries |
| rsFree | input | CNT_W | Free reservation-station entries |
| robEmpty | input | 1 | ROB holds nothing |
| drainMode | input | 1 | Drain-flush mode enable |
| drainStart | input | 1 | Recovery begins a drain |
| loadClr | input | 1 | Synchronous clear of the load counters |
| slotDone | output | SLOTS | Slot allocated this cycle |
| robIns | output | SLOTS | ROB insert strobe |
| ldqIns | output | SLOTS | Load-queue insert strobe |
| stqIns | output | SLOTS | Store-queue insert strobe |
| stqFill | output | SLOTS | Store data fills an existing entry |
| rsIns | output | SLOTS | Reservation-station insert strobe |
| portVld | output | SLOTS | Slot was bound to a port |
| portSel | output | SLOTS x PORT_W | Bound port index |
| readyTime | output | SLOTS x TIME_W | Computed ready time |
| issueNow | output | SLOTS | Bypass micro-op issued this cycle |
| completeNow | output | SLOTS | Bypass micro-op completed this cycle |
| stallCode | output | 3 | Stall reason |
| drainBusy | output | 1 | Drain in progress |

## Verification
The bench uses the default build: two slots, four ports, four classes, two sources per micro-op, 4-bit free counts and 3-bit load counters. With 3-bit counters the saturation point is only a few cycles away. With two slots, the abort of a later slot and the same-cycle claim of entries can both be seen. One sweep covers every kind code and both fusion flags. In that sweep the free counts are set to 0, 1 or 2, so every outcome of the check chain comes up. A second stream of mixed classes exercises single-candidate binding, least-loaded choice, ties and periodic clears. A scripted sequence then exercises the drain gate.

// File: rtl/alloc_pkg.sv
package alloc_pkg;

  typedef enum logic [2:0] {
    K_ALU    = 3'd0,
    K_LOAD   = 3'd1,
    K_STA    = 3'd2,
    K_STD    = 3'd3,
    K_LFENCE = 3'd4,
    K_SFENCE = 3'd5,
    K_NOP    = 3'd6,
    K_TRAP   = 3'd7
  } uopKind_e;

  typedef enum logic [2:0] {
    ST_NONE  = 3'd0,
    ST_DRAIN = 3'd1,
    ST_ROB   = 3'd2,
    ST_LDQ   = 3'd3,
    ST_STQ   = 3'd4,
    ST_RS    = 3'd5
  } stall_e;

  // Strobes from control to datapath, one per slot
  typedef struct packed {
    logic grant;    // slot allocated this cycle
    logic execute;  // slot goes through issue and needs a port
  } slotStrobe_t;

  function automatic logic kindExecutes(input logic [2:0] k);
    return (k == K_ALU) || (k == K_LOAD) || (k == K_STA) || (k == K_STD);
  endfunction

endpackage

// File: rtl/alloc_ctrl.sv
module alloc_ctrl
  import alloc_pkg::*;
#(
  parameter int SLOTS = 2,
  parameter int CNT_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [SLOTS-1:0]        slotValid,
  input  logic [SLOTS-1:0][2:0]   slotKind,
  input  logic [SLOTS-1:0]        slotFuseBody,
  input  logic [CNT_W-1:0]        robFree,
  input  logic [CNT_W-1:0]        ldqFree,
  input  logic [CNT_W-1:0]        stqFree,
  input  logic [CNT_W-1:0]        rsFree,
  input  logic                    robEmpty,
  input  logic                    drainMode,
  input  logic                    drainStart,
  output slotStrobe_t [SLOTS-1:0] strobe,
  output logic [SLOTS-1:0]        robIns,
  output logic [SLOTS-1:0]        ldqIns,
  output logic [SLOTS-1:0]        stqIns,
  output logic [SLOTS-1:0]        stqFill,
  output logic [SLOTS-1:0]        rsIns,
  output logic [SLOTS-1:0]        issueNow,
  output logic [SLOTS-1:0]        completeNow,
  output logic [2:0]              stallCode,
  output logic                    drainBusy
);

  localparam int USE_W = CNT_W + 1;

  logic   drainHold;
  stall_e code;

  assign drainHold = drainBusy && !robEmpty;
  assign stallCode = code;

  // Drain state: set by a recovery in drain mode, cleared once the ROB empties
  always_ff @(posedge clk) begin
    if (!rstN) begin
      drainBusy <= 1'b0;
    end else if (drainStart && drainMode) begin
      drainBusy <= 1'b1;
    end else if (drainBusy && robEmpty) begin
      drainBusy <= 1'b0;
    end
  end

  // Ordered resource checks chained across slots
  always_comb begin : checkChain
    logic [USE_W-1:0] usedRob, usedLdq, usedStq, usedRs;
    logic             halted;
    logic             wantRob, wantLdq, wantStq, wantRs, runs;
    logic [2:0]       k;
    usedRob = '0;
    usedLdq = '0;
    usedStq = '0;
    usedRs  = '0;
    halted  = drainHold;
    code    = drainHold ? ST_DRAIN : ST_NONE;
    for (int i = 0; i < SLOTS; i++) begin
      strobe[i]      = '0;
      robIns[i]      = 1'b0;
      ldqIns[i]      = 1'b0;
      stqIns[i]      = 1'b0;
      stqFill[i]     = 1'b0;
      rsIns[i]       = 1'b0;
      issueNow[i]    = 1'b0;
      completeNow[i] = 1'b0;
      k       = slotKind[i];
      runs    = kindExecutes(k);
      wantRob = !slotFuseBody[i];
      wantLdq = (k == K_LOAD) || (k == K_LFENCE);
      wantStq = (k == K_STA) || (k == K_SFENCE);
      wantRs  = runs && !slotFuseBody[i];
      if (!halted && slotValid[i]) begin
        if (wantRob && (usedRob >= {1'b0, robFree})) begin
          code   = ST_ROB;
          halted = 1'b1;
        end else if (wantLdq && (usedLdq >= {1'b0, ldqFree})) begin
          code   = ST_LDQ;
          halted = 1'b1;
        end else if (wantStq && (usedStq >= {1'b0, stqFree})) begin
          code   = ST_STQ;
          halted = 1'b1;
        end else if (wantRs && (usedRs >= {1'b0, rsFree})) begin
          code   = ST_RS;
          halted = 1'b1;
        end else begin
          strobe[i].grant   = 1'b1;
          strobe[i].execute = runs;
          robIns[i]  = wantRob;
          ldqIns[i]  = wantLdq;
          stqIns[i]  = wantStq;
          stqFill[i] = (k == K_STD);
          rsIns[i]   = wantRs;
          issueNow[i]    = !runs;
          completeNow[i] = !runs && (k != K_LFENCE);
          usedRob = usedRob + USE_W'(wantRob);
          usedLdq = usedLdq + USE_W'(wantLdq);
          usedStq = usedStq + USE_W'(wantStq);
          usedRs  = usedRs  + USE_W'(wantRs);
        end
      end
    end
  end

endmodule

// File: rtl/alloc_dp.sv
module alloc_dp
  import alloc_pkg::*;
#(
  parameter int SLOTS       = 2,
  parameter int NUM_PORTS   = 4,
  parameter int NUM_CLASSES = 4,
  parameter int NUM_SRC     = 2,
  parameter int TIME_W      = 16,
  parameter int LOAD_W      = 3,
  parameter logic [NUM_CLASSES*NUM_PORTS-1:0] CLASS_PORTS = 16'b0011_1000_0100_1011,
  localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CLS_W      = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  loadClr,
  input  slotStrobe_t [SLOTS-1:0]               strobe,
  input  logic [SLOTS-1:0][CLS_W-1:0]           slotClass,
  input  logic [SLOTS-1:0][NUM_SRC-1:0]         srcLive,
  input  logic [SLOTS-1:0][NUM_SRC-1:0][TIME_W-1:0] srcTime,
  input  logic [TIME_W-1:0]                     curTime,
  output logic [SLOTS-1:0][PORT_W-1:0]          portSel,
  output logic [SLOTS-1:0][TIME_W-1:0]          readyTime
);

  localparam logic [LOAD_W-1:0] LOAD_MAX = '1;

  logic [LOAD_W-1:0] loadCnt  [NUM_PORTS];
  logic [LOAD_W-1:0] loadNext [NUM_PORTS];

  // Least-loaded selection; each slot sees the loads left by the slots before it
  always_comb begin : bindChain
    logic [LOAD_W-1:0] view [NUM_PORTS];
    logic [LOAD_W-1:0] bestLoad;
    int                best;
    logic              found;
    for (int p = 0; p < NUM_PORTS; p++) view[p] = loadCnt[p];
    for (int i = 0; i < SLOTS; i++) begin
      best     = 0;
      bestLoad = '0;
      found    = 1'b0;
      if (strobe[i].grant && strobe[i].execute) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (CLASS_PORTS[int'(slotClass[i])*NUM_PORTS + p] &&
              (!found || (view[p] < bestLoad))) begin
            best     = p;
            bestLoad = view[p];
            found    = 1'b1;
          end
        end
        if (found && (view[best] != LOAD_MAX)) begin
          view[best] = view[best] + 1'b1;
        end
      end
      portSel[i] = PORT_W'(best);
    end
    for (int p = 0; p < NUM_PORTS; p++) loadNext[p] = view[p];
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (!rstN || loadClr) loadCnt[p] <= '0;
      else                  loadCnt[p] <= loadNext[p];
    end
  end

  // Ready time per slot
  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_ready
    always_comb begin
      logic [TIME_W-1:0] latest;
      logic [TIME_W-1:0] cand;
      latest = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
        cand = srcLive[gi][s] ? srcTime[gi][s] : curTime;
        if (cand > latest) latest = cand;
      end
      readyTime[gi] = strobe[gi].execute ? latest : curTime;
    end
  end

endmodule

// File: rtl/alloc_stage.sv
module alloc_stage
  import alloc_pkg::*;
#(
  parameter int SLOTS       = 2,
  parameter int NUM_PORTS   = 4,
  parameter int NUM_CLASSES = 4,
  parameter int NUM_SRC     = 2,
  parameter int TIME_W      = 16,
  parameter int CNT_W       = 4,
  parameter int LOAD_W      = 3,
  parameter logic [NUM_CLASSES*NUM_PORTS-1:0] CLASS_PORTS = 16'b0011_1000_0100_1011,
  localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CLS_W      = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic [TIME_W-1:0]                         curTime,
  input  logic [SLOTS-1:0]                          slotValid,
  input  logic [SLOTS-1:0][2:0]                     slotKind,
  input  logic [SLOTS-1:0]                          slotFuseBody,
  input  logic [SLOTS-1:0][CLS_W-1:0]               slotClass,
  input  logic [SLOTS-1:0][NUM_SRC-1:0]             srcLive,
  input  logic [SLOTS-1:0][NUM_SRC-1:0][TIME_W-1:0] srcTime,
  input  logic [CNT_W-1:0]                          robFree,
  input  logic [CNT_W-1:0]                          ldqFree,
  input  logic [CNT_W-1:0]                          stqFree,
  input  logic [CNT_W-1:0]                          rsFree,
  input  logic                                      robEmpty,
  input  logic                                      drainMode,
  input  logic                                      drainStart,
  input  logic                                      loadClr,
  output logic [SLOTS-1:0]                          slotDone,
  output logic [SLOTS-1:0]                          robIns,
  output logic [SLOTS-1:0]                          ldqIns,
  output logic [SLOTS-1:0]                          stqIns,
  output logic [SLOTS-1:0]                          stqFill,
  output logic [SLOTS-1:0]                          rsIns,
  output logic [SLOTS-1:0]                          portVld,
  output logic [SLOTS-1:0][PORT_W-1:0]              portSel,
  output logic [SLOTS-1:0][TIME_W-1:0]              readyTime,
  output logic [SLOTS-1:0]                          issueNow,
  output logic [SLOTS-1:0]                          completeNow,
  output logic [2:0]                                stallCode,
  output logic                                      drainBusy
);

  slotStrobe_t [SLOTS-1:0] strobe;

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_strobe
    assign slotDone[gi] = strobe[gi].grant;
    assign portVld[gi]  = strobe[gi].grant & strobe[gi].execute;
  end

  alloc_ctrl #(
    .SLOTS (SLOTS),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .slotValid    (slotValid),
    .slotKind     (slotKind),
    .slotFuseBody (slotFuseBody),
    .robFree      (robFree),
    .ldqFree      (ldqFree),
    .stqFree      (stqFree),
    .rsFree       (rsFree),
    .robEmpty     (robEmpty),
    .drainMode    (drainMode),
    .drainStart   (drainStart),
    .strobe       (strobe),
    .robIns       (robIns),
    .ldqIns       (ldqIns),
    .stqIns       (stqIns),
    .stqFill      (stqFill),
    .rsIns        (rsIns),
    .issueNow     (issueNow),
    .completeNow  (completeNow),
    .stallCode    (stallCode),
    .drainBusy    (drainBusy)
  );

  alloc_dp #(
    .SLOTS       (SLOTS),
    .NUM_PORTS   (NUM_PORTS),
    .NUM_CLASSES (NUM_CLASSES),
    .NUM_SRC     (NUM_SRC),
    .TIME_W      (TIME_W),
    .LOAD_W      (LOAD_W),
    .CLASS_PORTS (CLASS_PORTS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .loadClr   (loadClr),
    .strobe    (strobe),
    .slotClass (slotClass),
    .srcLive   (srcLive),
    .srcTime   (srcTime),
    .curTime   (curTime),
    .portSel   (portSel),
    .readyTime (readyTime)
  );

endmodule

// File: rtl/alloc_stage_chk.sv
module alloc_stage_chk #(
  parameter int SLOTS = 2,
  parameter int CNT_W = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [SLOTS-1:0]      slotValid,
  input logic [SLOTS-1:0][2:0] slotKind,
  input logic [SLOTS-1:0]      slotFuseBody,
  input logic [CNT_W-1:0]      robFree,
  input logic [CNT_W-1:0]      rsFree,
  input logic                  robEmpty,
  input logic                  drainMode,
  input logic                  drainStart,
  input logic [SLOTS-1:0]      slotDone,
  input logic [SLOTS-1:0]      robIns,
  input logic [SLOTS-1:0]      stqIns,
  input logic [SLOTS-1:0]      stqFill,
  input logic [SLOTS-1:0]      rsIns,
  input logic [SLOTS-1:0]      portVld,
  input logic [SLOTS-1:0]      issueNow,
  input logic [2:0]            stallCode,
  input logic                  drainBusy
);

  a_r1_code_range: assert property (@(posedge clk) disable iff (!rstN)
    stallCode <= 3'd5);

  a_r3_rob_budget: assert property (@(posedge clk) disable iff (!rstN)
    $countones(robIns) <= int'(robFree));

  a_r3_rs_budget: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rsIns) <= int'(rsFree));

  a_r11_drain_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (drainBusy && !robEmpty) |-> (slotDone == '0 && stallCode == 3'd1));

  a_r11_drain_sets: assert property (@(posedge clk) disable iff (!rstN)
    (drainStart && drainMode) |=> drainBusy);

  a_r11_drain_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!drainBusy && !drainMode) |=> !drainBusy);

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    a_r2_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
      slotDone[gi] |-> slotValid[gi]);

    a_r4_body_no_rob: assert property (@(posedge clk) disable iff (!rstN)
      (robIns[gi] || rsIns[gi]) |-> !slotFuseBody[gi]);

    a_r5_fill_no_claim: assert property (@(posedge clk) disable iff (!rstN)
      stqFill[gi] |-> (!stqIns[gi] && slotKind[gi] == 3'd3));

    a_r6_bypass_unbound: assert property (@(posedge clk) disable iff (!rstN)
      (slotDone[gi] && slotKind[gi] >= 3'd4) |-> (!portVld[gi] && issueNow[gi] && !rsIns[gi]));
  end

endmodule

bind alloc_stage alloc_stage_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .slotValid    (slotValid),
  .slotKind     (slotKind),
  .slotFuseBody (slotFuseBody),
  .robFree      (robFree),
  .rsFree       (rsFree),
  .robEmpty     (robEmpty),
  .drainMode    (drainMode),
  .drainStart   (drainStart),
  .slotDone     (slotDone),
  .robIns       (robIns),
  .stqIns       (stqIns),
  .stqFill      (stqFill),
  .rsIns        (rsIns),
  .portVld      (portVld),
  .issueNow     (issueNow),
  .stallCode    (stallCode),
  .drainBusy    (drainBusy)
);

// File: tb/alloc_stage_bench.sv
`timescale 1ns/1ps
module alloc_stage_bench;

  localparam int SLOTS = 2, NP = 4, NC = 4, NS = 2, TW = 16, CW = 4, LW = 3;
  localparam int PW = 2, CLW = 2;
  localparam logic [NC*NP-1:0] CPORTS = 16'b0011_1000_0100_1011;
  localparam int LMAX = (1 << LW) - 1;

  logic clk = 1'b0;
  logic rstN;
  logic [TW-1:0] curTime;
  logic [SLOTS-1:0] slotValid, slotFuseBody;
  logic [SLOTS-1:0][2:0] slotKind;
  logic [SLOTS-1:0][CLW-1:0] slotClass;
  logic [SLOTS-1:0][NS-1:0] srcLive;
  logic [SLOTS-1:0][NS-1:0][TW-1:0] srcTime;
  logic [CW-1:0] robFree, ldqFree, stqFree, rsFree;
  logic robEmpty, drainMode, drainStart, loadClr;
  logic [SLOTS-1:0] slotDone, robIns, ldqIns, stqIns, stqFill, rsIns, portVld, issueNow, completeNow;
  logic [SLOTS-1:0][PW-1:0] portSel;
  logic [SLOTS-1:0][TW-1:0] readyTime;
  logic [2:0] stallCode;
  logic drainBusy;

  always #2.5 clk = ~clk;

  alloc_stage u_alloc_stage (.*);

  int nTests = 0, nFail = 0;
  bit finished = 1'b0;
  int mLoad [NP];
  bit mBusy;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Evaluate one cycle against the requirement model, then advance the model
  task automatic evalCycle();
    int code, uRob, uLdq, uStq, uRs;
    bit stop;
    int view [NP];
    int k, fb, wR, wL, wS, wX, ex;
    bit eDone, eRob, eLdq, eStq, eFill, eRs, ePv, eIss, eCmp;
    int ePort, eReady, best, cand;
    for (int p = 0; p < NP; p++) view[p] = mLoad[p];
    uRob = 0; uLdq = 0; uStq = 0; uRs = 0;
    stop = mBusy && !robEmpty;
    code = stop ? 1 : 0;
    chk(drainBusy == mBusy, "R11", "drainBusy", drainBusy, mBusy);
    for (int i = 0; i < SLOTS; i++) begin
      k = slotKind[i]; fb = slotFuseBody[i];
      ex = (k <= 3);
      wR = !fb; wL = (k == 1 || k == 4); wS = (k == 2 || k == 5); wX = ex && !fb;
      eDone = 0; eRob = 0; eLdq = 0; eStq = 0; eFill = 0; eRs = 0; ePv = 0; eIss = 0; eCmp = 0;
      ePort = 0; eReady = curTime;
      if (!stop && slotValid[i]) begin
        if (wR && uRob >= robFree) begin code = 2; stop = 1; end
        else if (wL && uLdq >= ldqFree) begin code = 3; stop = 1; end
        else if (wS && uStq >= stqFree) begin code = 4; stop = 1; end
        else if (wX && uRs >= rsFree) begin code = 5; stop = 1; end
        else begin
          eDone = 1; eRob = wR; eLdq = wL; eStq = wS; eRs = wX; eFill = (k == 3);
          uRob += wR; uLdq += wL; uStq += wS; uRs += wX;
          if (ex) begin
            ePv = 1; best = -1; eReady = 0;
            for (int p = 0; p < NP; p++)
              if (CPORTS[slotClass[i]*NP + p] && (best < 0 || view[p] < view[best])) best = p;
            ePort = best;
            if (view[best] < LMAX) view[best]++;
            for (int s = 0; s < NS; s++) begin
              cand = srcLive[i][s] ? srcTime[i][s] : curTime;
              if (cand > eReady) eReady = cand;
            end
          end else begin
            eIss = 1; eCmp = (k != 4);
          end
        end
      end
      chk(slotDone[i] == eDone, "R2", "slotDone", slotDone[i], eDone);
      chk(robIns[i] == eRob && rsIns[i] == eRs, "R4", "rob/rs strobes", {robIns[i], rsIns[i]}, {eRob, eRs});
      chk(ldqIns[i] == eLdq && stqIns[i] == eStq && stqFill[i] == eFill, "R5", "queue strobes",
          {ldqIns[i], stqIns[i], stqFill[i]}, {eLdq, eStq, eFill});
      chk(portVld[i] == ePv && issueNow[i] == eIss && completeNow[i] == eCmp, "R6", "bypass flags",
          {portVld[i], issueNow[i], completeNow[i]}, {ePv, eIss, eCmp});
      if (ePv) chk(portSel[i] == ePort, "R8", "portSel", portSel[i], ePort);
      if (eDone) chk(readyTime[i] == eReady, "R10", "readyTime", readyTime[i], eReady);
    end
    chk(stallCode == code, "R1", "stallCode", stallCode, code);
    for (int p = 0; p < NP; p++) mLoad[p] = loadClr ? 0 : view[p];
    if (drainStart && drainMode) mBusy = 1;
    else if (mBusy && robEmpty) mBusy = 0;
  endtask

  task automatic idleInputs();
    curTime = 16'd20; slotValid = '0; slotKind = '0; slotFuseBody = '0; slotClass = '0;
    srcLive = '0; srcTime = '0; robFree = 4'd15; ldqFree = 4'd15; stqFree = 4'd15; rsFree = 4'd15;
    robEmpty = 1'b0; drainMode = 1'b0; drainStart = 1'b0; loadClr = 1'b0;
  endtask

  task automatic tick();
    #1;
    evalCycle();
    @(negedge clk);
  endtask

  initial begin
    idleInputs();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int p = 0; p < NP; p++) mLoad[p] = 0;
    mBusy = 0;
    // R12: reset state, then first class-0 binding must land on port 0
    #1;
    chk(drainBusy == 1'b0, "R12", "drainBusy after reset", drainBusy, 0);
    chk(stallCode == 3'd0, "R12", "stallCode after reset", stallCode, 0);
    slotValid = 2'b01; slotKind[0] = 3'd0; slotClass[0] = '0;
    #1;
    chk(portSel[0] == 2'd0, "R12", "first port after reset", portSel[0], 0);
    evalCycle();
    @(negedge clk);

    // Sweep of kinds, fusion flags and free counts (R1-R6, R10)
    for (int v = 0; v < 512; v++) begin
      idleInputs();
      loadClr = 1'b1;
      slotValid = (v % 11 == 5) ? 2'b10 : 2'b11;
      slotKind[0] = v[2:0]; slotFuseBody[0] = v[3];
      slotKind[1] = v[8] ? 3'd1 : 3'd0; slotClass[1] = 2'(v % 4); slotClass[0] = 2'((v / 3) % 4);
      robFree = v[4] ? CW'((v % 3 == 0) ? 2 : 1) : '0;
      ldqFree = v[5] ? CW'((v % 3 == 1) ? 2 : 1) : '0;
      stqFree = v[6] ? 4'd1 : '0;
      rsFree  = v[7] ? CW'((v % 3 == 2) ? 2 : 1) : '0;
      srcLive = 4'(v * 5);
      srcTime[0][0] = TW'((v * 7) % 40);  srcTime[0][1] = TW'((v * 13) % 40);
      srcTime[1][0] = TW'((v * 3) % 40);  srcTime[1][1] = TW'((v * 11) % 40);
      tick();
    end

    // Port balancing stream (R7, R8, R9)
    for (int v = 0; v < 240; v++) begin
      idleInputs();
      slotValid = (v % 7 == 3) ? 2'b10 : 2'b11;
      slotClass[0] = 2'(v % 4); slotClass[1] = 2'((v / 4) % 4);
      slotKind[0] = (v % 5 == 0) ? 3'd1 : 3'd0; slotKind[1] = 3'd0;
      slotFuseBody[1] = v[4];
      loadClr = (v % 60 == 59);
      tick();
    end
    // R7: class 1 has only port 2
    idleInputs(); slotValid = 2'b11; slotClass[0] = 2'd1; slotClass[1] = 2'd1;
    #1;
    chk(portSel[0] == 2'd2 && portSel[1] == 2'd2, "R7", "single candidate", portSel[0], 2);
    evalCycle(); @(negedge clk);
    // R9: after a clear with increments pending, class 0 starts again at port 0
    idleInputs(); slotValid = 2'b11; loadClr = 1'b1; tick();
    idleInputs(); slotValid = 2'b01;
    #1;
    chk(portSel[0] == 2'd0, "R9", "clear wins over increment", portSel[0], 0);
    evalCycle(); @(negedge clk);

    // Drain sequence (R11)
    idleInputs(); slotValid = 2'b11; drainStart = 1'b1; tick();   // mode off: ignored
    idleInputs(); slotValid = 2'b11; #1;
    chk(drainBusy == 1'b0, "R11", "start ignored when mode off", drainBusy, 0);
    evalCycle(); @(negedge clk);
    idleInputs(); slotValid = 2'b11; drainMode = 1'b1; drainStart = 1'b1; tick();
    for (int c = 0; c < 3; c++) begin
      idleInputs(); slotValid = 2'b11; drainMode = 1'b1; tick();
    end
    idleInputs(); slotValid = 2'b11; drainMode = 1'b1; robEmpty = 1'b1; #1;
    chk(slotDone == 2'b11, "R11", "allocation resumes on empty ROB", slotDone, 3);
    evalCycle(); @(negedge clk);
    idleInputs(); slotValid = 2'b11; drainMode = 1'b1; tick();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule